// File: doc/BRIEF.md
# Windowed Register File with Overlapping Procedure Frames

This block is a register file for a processor that gives each active procedure its own frame of registers. The frames sit in a ring of physical storage. Next to the ring is a small bank of global registers that every frame sees. Two read ports and one write port take 5-bit architectural register numbers. A frame pointer turns each number into a physical location.

Call and return inputs move the frame pointer by one position around the ring. Neighbouring frames share eight registers: the registers a caller writes as its outgoing arguments are the ones the callee reads as its incoming arguments, so no data is copied. A separate boundary pointer marks the one frame whose contents currently live in memory. A call or return that would step onto that frame raises a trap and leaves the pointer unchanged. A trap handler saves or restores the frame in memory. It then rewrites both pointers through a dedicated update input and retries the operation.

Top module: `winreg_file`

## Requirements
- R1: Architectural register 0 always reads as zero on both read ports, and writes to it are ignored.
- R2: Architectural registers 1 to 7 are global: the same storage is seen whatever the frame pointer holds.
- R3: Each frame presents 24 windowed registers:
  - numbers 24 to 31 are the incoming group;
  - numbers 16 to 23 are the local group;
  - numbers 8 to 15 are the outgoing group.
  
  The local group of one frame is not visible from any other frame.
- R4: The outgoing group of frame w is the same storage as the incoming group of frame (w+1) mod NWIN. This includes the wrap from frame NWIN-1 to frame 0.
- R5: A call with no trap advances the frame pointer to (cwp+1) mod NWIN at the next clock edge. A return with no trap moves it to (cwp-1) mod NWIN.
- R6: When a call's target frame equals the boundary pointer, ovf_trap is high in that same cycle, and the frame pointer keeps its value.
- R7: When a return's target frame equals the boundary pointer, unf_trap is high in that same cycle, and the frame pointer keeps its value.
- R8: After reset, cwp is 0 and swp is NWIN-1. With that state, NWIN-2 calls succeed in a row and the next call traps.
- R9: When ptr_wr_en is high, cwp and swp load ptr_cwp and ptr_swp at the next edge. This takes priority over call and return, and no trap is raised in that cycle.
- R10: If call and return are both high in the same cycle, nothing happens: there is no pointer change and no trap.
- R11: A read of a register that is being written in the same cycle returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointers and globals |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | DW | Write data |
| call | input | 1 | Advance to the next frame |
| ret | input | 1 | Go back to the previous frame |
| ptr_wr_en | input | 1 | Handler load of both pointers |
| ptr_cwp | input | CW | Frame pointer value to load |
| ptr_swp | input | CW | Boundary pointer value to load |
| cwp | output | CW | Current frame pointer |
| swp | output | CW | Boundary (saved-frame) pointer |
| ovf_trap | output | 1 | Call blocked: out of frames |
| unf_trap | output | 1 | Return blocked: frame must be restored |

## Verification
Register mapping is tried with four patterns:
- a write to a global register, read back from another frame, which separates global from windowed decoding;
- a write to an outgoing register, read as an incoming register after a call, which shows the overlap;
- a local register rewritten in a callee and read back after return, which shows that frames are private;
- an outgoing write in the last frame, read as incoming in frame 0, which exposes wrap errors in the modulo arithmetic.

Pointer control is tried with:
- a run of calls up to the trap;
- a handler reload followed by a retry;
- a run of returns down to the underflow trap;
- a call and a return asserted together.

Together these tell correct movement apart from off-by-one trap boundaries.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int NPHY = NWIN * 16,
  localparam int PW  = $clog2(NPHY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          call,
  input  logic          ret,
  input  logic          ptr_wr_en,
  input  logic [CW-1:0] ptr_cwp,
  input  logic [CW-1:0] ptr_swp,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] swp,
  output logic          ovf_trap,
  output logic          unf_trap
);

  logic [DW-1:0] glob [1:7];
  logic [DW-1:0] wins [NPHY];
  logic [CW-1:0] nxt_w, prv_w;

  function automatic logic [PW-1:0] phys(input logic [4:0] a, input logic [CW-1:0] w);
    int off, s;
    if (a >= 5'd24)      off = int'(a) - 24;
    else if (a >= 5'd16) off = int'(a) - 8;
    else                 off = int'(a) + 8;
    s = int'(w) * 16 + off;
    if (s >= NPHY) s = s - NPHY;
    return PW'(s);
  endfunction

  function automatic logic [DW-1:0] rd(input logic [4:0] a);
    if (a == 5'd0)     return '0;
    else if (a < 5'd8) return glob[a[2:0]];
    else               return wins[phys(a, cwp)];
  endfunction

  assign nxt_w = (cwp == CW'(NWIN-1)) ? '0 : cwp + 1'b1;
  assign prv_w = (cwp == '0) ? CW'(NWIN-1) : cwp - 1'b1;

  wire solo_call = call & ~ret & ~ptr_wr_en;
  wire solo_ret  = ret & ~call & ~ptr_wr_en;

  assign ovf_trap = solo_call & (nxt_w == swp);
  assign unf_trap = solo_ret  & (prv_w == swp);

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp <= '0;
      swp <= CW'(NWIN-1);
    end else if (ptr_wr_en) begin
      cwp <= ptr_cwp;
      swp <= ptr_swp;
    end else if (solo_call && !ovf_trap) begin
      cwp <= nxt_w;
    end else if (solo_ret && !unf_trap) begin
      cwp <= prv_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i < 8; i++) glob[i] <= '0;
    end else if (wr_en && wr_idx != 5'd0 && wr_idx < 5'd8) begin
      glob[wr_idx[2:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_en && wr_idx >= 5'd8)
      wins[phys(wr_idx, cwp)] <= wr_data;
  end

endmodule

module winreg_file_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    rd_a_idx,
  input logic [DW-1:0] rd_a_data,
  input logic          call,
  input logic          ret,
  input logic          ptr_wr_en,
  input logic [CW-1:0] ptr_cwp,
  input logic [CW-1:0] cwp,
  input logic          ovf_trap,
  input logic          unf_trap
);

  p_zero_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);

  p_call_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call && !ret && !ptr_wr_en && !ovf_trap) |=>
      cwp == (($past(cwp) == CW'(NWIN-1)) ? '0 : $past(cwp) + 1'b1));

  p_ret_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !call && !ptr_wr_en && !unf_trap) |=>
      cwp == (($past(cwp) == '0) ? CW'(NWIN-1) : $past(cwp) - 1'b1));

  p_no_overflow_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap && !ptr_wr_en) |=> $stable(cwp));

  p_no_underflow_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_trap && !ptr_wr_en) |=> $stable(cwp));

  p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> cwp == $past(ptr_cwp));

  p_both_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (call && ret) |-> !ovf_trap && !unf_trap);

endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .call(call), .ret(ret), .ptr_wr_en(ptr_wr_en), .ptr_cwp(ptr_cwp),
  .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
);

// File: tb/winreg_file_test.sv
module winreg_file_test;
  localparam int N = 8;
  localparam int DW = 32;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra = 0, rb = 0, wi = 0;
  logic [DW-1:0] ad, bd, wd = 0;
  logic we = 0, call = 0, ret = 0, pwe = 0;
  logic [CW-1:0] pc = 0, ps = 0, cwp, swp;
  logic ovf, unf;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  winreg_file #(.NWIN(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(ra), .rd_a_data(ad),
    .rd_b_idx(rb), .rd_b_data(bd), .wr_en(we), .wr_idx(wi), .wr_data(wd),
    .call(call), .ret(ret), .ptr_wr_en(pwe), .ptr_cwp(pc), .ptr_swp(ps),
    .cwp(cwp), .swp(swp), .ovf_trap(ovf), .unf_trap(unf));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    we = 0; call = 0; ret = 0; pwe = 0;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(input logic [4:0] i, input logic [DW-1:0] d);
    we = 1; wi = i; wd = d; cyc();
  endtask

  task automatic rdchk(input string req, input logic [4:0] i, input logic [DW-1:0] exp);
    ra = i; rb = i; #1;
    chk(req, ad, exp); chk(req, bd, exp);
  endtask

  task automatic do_call(); call = 1; cyc(); endtask
  task automatic do_ret();  ret = 1;  cyc(); endtask
  task automatic load(input logic [CW-1:0] c, input logic [CW-1:0] s);
    pwe = 1; pc = c; ps = s; cyc();
  endtask

  task automatic t_reset();
    chk("R8 cwp", 32'(cwp), 0);
    chk("R8 swp", 32'(swp), N-1);
    chk("R8 traps", {ovf, unf}, 0);
  endtask

  task automatic t_zero();
    wr(5'd0, 32'hDEAD_BEEF);
    rdchk("R1", 5'd0, 0);
  endtask

  task automatic t_global();
    wr(5'd5, 32'h1234_5678);
    do_call(); do_call();
    rdchk("R2", 5'd5, 32'h1234_5678);
    do_ret(); do_ret();
  endtask

  task automatic t_overlap();
    wr(5'd9, 32'hA0A0_0001);
    do_call();
    rdchk("R4 in", 5'd25, 32'hA0A0_0001);
    wr(5'd26, 32'h0000_BEEF);
    do_ret();
    rdchk("R4 out", 5'd10, 32'h0000_BEEF);
  endtask

  task automatic t_local();
    wr(5'd18, 32'h1111_1111);
    do_call();
    wr(5'd18, 32'h2222_2222);
    rdchk("R3 callee", 5'd18, 32'h2222_2222);
    do_ret();
    rdchk("R3 caller", 5'd18, 32'h1111_1111);
  endtask

  task automatic t_rdw();
    wr(5'd20, 32'h0000_0005);
    we = 1; wi = 5'd20; wd = 32'h0000_0009; ra = 5'd20; #1;
    chk("R11 old", ad, 32'h0000_0005);
    cyc();
    rdchk("R11 new", 5'd20, 32'h0000_0009);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < N-2; k++) begin
      call = 1; #1;
      chk("R6 no trap", 32'(ovf), 0);
      cyc();
    end
    chk("R5 cwp", 32'(cwp), N-2);
    call = 1; #1;
    chk("R6 trap", 32'(ovf), 1);
    cyc();
    chk("R6 hold", 32'(cwp), N-2);
  endtask

  task automatic t_handler();
    load(3'(N-2), 3'd0);
    chk("R9 swp", 32'(swp), 0);
    call = 1; #1;
    chk("R9 retry", 32'(ovf), 0);
    cyc();
    chk("R5 retry cwp", 32'(cwp), N-1);
    wr(5'd12, 32'hCAFE_0007);
    load(3'd0, 3'd0);
    rdchk("R4 wrap", 5'd28, 32'hCAFE_0007);
    load(3'(N-1), 3'd0);
  endtask

  task automatic t_underflow();
    for (int k = N-1; k > 1; k--) begin
      ret = 1; #1;
      chk("R7 no trap", 32'(unf), 0);
      cyc();
    end
    chk("R5 ret cwp", 32'(cwp), 1);
    ret = 1; #1;
    chk("R7 trap", 32'(unf), 1);
    cyc();
    chk("R7 hold", 32'(cwp), 1);
  endtask

  task automatic t_both();
    call = 1; ret = 1; #1;
    chk("R10 traps", {ovf, unf}, 0);
    cyc();
    chk("R10 cwp", 32'(cwp), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_zero(); t_global(); t_overlap(); t_local();
        t_rdw(); t_overflow(); t_handler(); t_underflow(); t_both();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule